// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block sits on the receive path just after the start-of-frame delimiter has been stripped. It watches the first six bytes of each frame, which hold the 48-bit destination address. From those bytes it decides whether the frame should be kept. The decision uses the address class, exact comparison against a node address and a set of supplemental addresses, a promiscuous control, and two 64-bin hash tables. One hash table serves group addresses and the other serves individual addresses.

The bytes arrive on `byte_in`, qualified by `byte_vld`, and `sof` marks the first byte of a frame. Idle cycles may fall between address bytes. Configuration arrives on plain inputs that are held stable while a frame is in flight. One clock after the sixth address byte, the block raises a single-cycle `dec_vld` strobe together with the verdict and the class flags. The verdict and the flags then hold until the next frame starts. Bytes after the sixth one, such as payload, FCS and anything else, are ignored.

Top module: `eth_da_filter`

## Requirements
- R1: The address is taken as the six bytes in arrival order, with the first byte in bits [47:40]. Bit 0 of the first byte (address bit 40) gives the class: 0 is individual (`is_ucast`=1) and 1 is group (`is_mcast`=1).
- R2: An address with all 48 bits at 1 is broadcast. In that case only `is_bcast` is raised, and the frame is accepted unless `bcast_reject` is 1.
- R3: An individual address equal to `node_addr` or to any entry of `supp_addr` is accepted, whatever the hash tables and `promisc` hold.
- R4: When `promisc` is 1, every individual address is accepted.
- R5: The hash index is computed as follows. A 32-bit CRC starts at all ones and uses polynomial 0x04C11DB7. It processes the six bytes in arrival order, each byte least significant bit first, with feedback taken as the CRC's top bit XOR the data bit and no final inversion. The index is the top six bits of the result, CRC[31:26]. Index bit 5 selects the upper (`*_hi`) or lower (`*_lo`) 32-bit half, and index bits 4:0 select the bit within that half.
- R6: A non-broadcast group address is accepted exactly when its bin is set in the group table. The individual table, the exact addresses and `promisc` have no effect on it.
- R7: An individual address with no exact match and with `promisc` at 0 is accepted exactly when its bin is set in the individual table.
- R8: `dec_vld` is high for exactly one cycle, one clock after the sixth address byte, and exactly one class flag is high with it. `accept` and the flags then stay stable. They read 0 from the clock after the first byte of the next frame.
- R9: Cycles with `byte_vld` low between address bytes do not change the decision. Bytes after the sixth produce no further strobe and leave `accept` and the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof | input | 1 | Marks the first byte of a frame (qualified by byte_vld) |
| byte_vld | input | 1 | byte_in carries a frame byte this cycle |
| byte_in | input | 8 | Received frame byte |
| node_addr | input | 48 | Primary station address |
| supp_addr | input | NUM_SUPP x 48 | Supplemental station addresses |
| promisc | input | 1 | Accept every individual address |
| bcast_reject | input | 1 | Reject broadcast frames |
| grp_hash_hi | input | 32 | Group hash table, bins 32..63 |
| grp_hash_lo | input | 32 | Group hash table, bins 0..31 |
| ind_hash_hi | input | 32 | Individual hash table, bins 32..63 |
| ind_hash_lo | input | 32 | Individual hash table, bins 0..31 |
| dec_vld | output | 1 | One-cycle decision strobe |
| accept | output | 1 | Frame accepted |
| is_ucast | output | 1 | Individual address |
| is_mcast | output | 1 | Group address, not broadcast |
| is_bcast | output | 1 | Broadcast address |

## Verification
The hardest situation to reach from the ports is a specific hash bin. Only the CRC decides which of the 64 bits an address lands on, so a bin cannot be chosen by picking address bits directly. The bench therefore computes the CRC for a long run of group and individual addresses and reads off each address's bin. For each address it then loads a table with only that bin set, which must accept, and a table with every bin except that one set, which must reject. While the group table is being checked, the individual table is filled with ones, and the reverse, so that a lookup in the wrong table would show up.

// File: rtl/eth_da_filter.sv
module eth_da_filter #(
  parameter int          NUM_SUPP = 4,
  parameter logic [31:0] CRC_POLY = 32'h04C11DB7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sof,
  input  logic                     byte_vld,
  input  logic [7:0]               byte_in,
  input  logic [47:0]              node_addr,
  input  logic [NUM_SUPP-1:0][47:0] supp_addr,
  input  logic                     promisc,
  input  logic                     bcast_reject,
  input  logic [31:0]              grp_hash_hi,
  input  logic [31:0]              grp_hash_lo,
  input  logic [31:0]              ind_hash_hi,
  input  logic [31:0]              ind_hash_lo,
  output logic                     dec_vld,
  output logic                     accept,
  output logic                     is_ucast,
  output logic                     is_mcast,
  output logic                     is_bcast
);
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = 8 * ADDR_BYTES;
  localparam int CNT_W      = $clog2(ADDR_BYTES + 1);

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[31] ^ d[i]) ? ((r << 1) ^ CRC_POLY) : (r << 1);
    return r;
  endfunction

  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-9:0] addr_q;
  logic [31:0]       crc_q;

  wire start = sof & byte_vld;
  wire busy  = (cnt != '0) && (cnt < CNT_W'(ADDR_BYTES));
  wire take  = byte_vld & (start | busy);
  wire [CNT_W-1:0] cnt_nx = start ? CNT_W'(1) : cnt + CNT_W'(1);
  wire last  = take & ~start & (cnt_nx == CNT_W'(ADDR_BYTES));

  wire [ADDR_W-1:0] addr_nx = {addr_q, byte_in};
  wire [31:0]       crc_nx  = crc_step(start ? '1 : crc_q, byte_in);
  wire [5:0]        bin     = crc_nx[31:26];

  wire grp_bit = bin[5] ? grp_hash_hi[bin[4:0]] : grp_hash_lo[bin[4:0]];
  wire ind_bit = bin[5] ? ind_hash_hi[bin[4:0]] : ind_hash_lo[bin[4:0]];

  wire bc_nx = &addr_nx;
  wire ig_nx = addr_nx[ADDR_W-8];
  wire mc_nx = ig_nx & ~bc_nx;
  wire uc_nx = ~ig_nx;

  logic [NUM_SUPP:0] hit;
  assign hit[NUM_SUPP] = (addr_nx == node_addr);
  for (genvar g = 0; g < NUM_SUPP; g++) begin : g_supp
    assign hit[g] = (addr_nx == supp_addr[g]);
  end

  wire acc_nx = bc_nx ? ~bcast_reject :
                mc_nx ? grp_bit :
                        (promisc | (|hit) | ind_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      addr_q <= '0;
      crc_q  <= '0;
    end else if (take) begin
      cnt    <= cnt_nx;
      addr_q <= addr_nx[ADDR_W-9:0];
      crc_q  <= crc_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_vld  <= 1'b0;
      accept   <= 1'b0;
      is_ucast <= 1'b0;
      is_mcast <= 1'b0;
      is_bcast <= 1'b0;
    end else begin
      dec_vld <= last;
      if (start) begin
        accept   <= 1'b0;
        is_ucast <= 1'b0;
        is_mcast <= 1'b0;
        is_bcast <= 1'b0;
      end else if (last) begin
        accept   <= acc_nx;
        is_ucast <= uc_nx;
        is_mcast <= mc_nx;
        is_bcast <= bc_nx;
      end
    end
  end
endmodule

// File: rtl/eth_da_filter_chk.sv
module eth_da_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic sof,
  input logic byte_vld,
  input logic promisc,
  input logic bcast_reject,
  input logic dec_vld,
  input logic accept,
  input logic is_ucast,
  input logic is_mcast,
  input logic is_bcast
);
  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |=> !dec_vld);

  assert_class_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({is_ucast, is_mcast, is_bcast}));

  assert_class_at_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |-> $countones({is_ucast, is_mcast, is_bcast}) == 1);

  assert_clear_on_sof_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && byte_vld) |=> (!dec_vld && !accept && !is_ucast && !is_mcast && !is_bcast));

  assert_hold_after_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && !(sof && byte_vld)) |=> $stable({accept, is_ucast, is_mcast, is_bcast}));

  assert_promisc_unicast_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && is_ucast && $past(promisc)) |-> accept);

  assert_bcast_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && is_bcast) |-> (accept == !$past(bcast_reject)));
endmodule

bind eth_da_filter eth_da_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld),
  .promisc(promisc), .bcast_reject(bcast_reject), .dec_vld(dec_vld),
  .accept(accept), .is_ucast(is_ucast), .is_mcast(is_mcast), .is_bcast(is_bcast)
);

// File: tb/tb_eth_da_filter.sv
module tb_eth_da_filter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sof = 1'b0, byte_vld = 1'b0;
  logic [7:0] byte_in = '0;
  logic [47:0] node_addr = '0;
  logic [3:0][47:0] supp_addr = '0;
  logic promisc = 1'b0, bcast_reject = 1'b0;
  logic [31:0] grp_hash_hi = '0, grp_hash_lo = '0, ind_hash_hi = '0, ind_hash_lo = '0;
  logic dec_vld, accept, is_ucast, is_mcast, is_bcast;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  eth_da_filter dut (
    .clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld), .byte_in(byte_in),
    .node_addr(node_addr), .supp_addr(supp_addr), .promisc(promisc),
    .bcast_reject(bcast_reject), .grp_hash_hi(grp_hash_hi), .grp_hash_lo(grp_hash_lo),
    .ind_hash_hi(ind_hash_hi), .ind_hash_lo(ind_hash_lo), .dec_vld(dec_vld),
    .accept(accept), .is_ucast(is_ucast), .is_mcast(is_mcast), .is_bcast(is_bcast));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] bin_of(input logic [47:0] a);
    logic [31:0] c;
    c = '1;
    for (int b = 0; b < 6; b++)
      for (int k = 0; k < 8; k++) begin
        logic fb;
        fb = c[31] ^ a[47 - 8*b - 7 + k];
        c = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
      end
    return c[31:26];
  endfunction

  function automatic logic tbl_bit(input logic [31:0] hi, input logic [31:0] lo, input logic [5:0] n);
    return n[5] ? hi[n[4:0]] : lo[n[4:0]];
  endfunction

  function automatic logic exp_acc(input logic [47:0] a);
    if (&a) return !bcast_reject;
    if (a[40]) return tbl_bit(grp_hash_hi, grp_hash_lo, bin_of(a));
    if (promisc || a == node_addr) return 1'b1;
    for (int s = 0; s < 4; s++) if (a == supp_addr[s]) return 1'b1;
    return tbl_bit(ind_hash_hi, ind_hash_lo, bin_of(a));
  endfunction

  task automatic frame(input logic [47:0] a, input bit gap, input string req);
    logic [2:0] cls;
    logic ea;
    cls = (&a) ? 3'b001 : (a[40] ? 3'b010 : 3'b100);
    ea  = exp_acc(a);
    @(negedge clk); sof = 1'b1; byte_vld = 1'b1; byte_in = a[47:40];
    for (int i = 1; i < 6; i++) begin
      @(negedge clk);
      if (i == 1) chk("R8 cleared after first byte",
                      {dec_vld, accept, is_ucast, is_mcast, is_bcast}, 0);
      sof = 1'b0;
      if (gap) begin byte_vld = 1'b0; @(negedge clk); end
      byte_vld = 1'b1; byte_in = a[47 - 8*i -: 8];
    end
    @(negedge clk);
    byte_vld = 1'b1; byte_in = 8'hFF;
    chk("R8 strobe", dec_vld, 1);
    chk({req, " accept"}, accept, ea);
    chk("R1/R2 class", {is_ucast, is_mcast, is_bcast}, cls);
    @(negedge clk);
    byte_in = 8'h00;
    chk("R9 no second strobe", dec_vld, 0);
    chk("R9 hold after trailing byte", {accept, is_ucast, is_mcast, is_bcast}, {ea, cls});
    @(negedge clk); byte_vld = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [47:0] a;
    logic [5:0] n;
    repeat (3) @(negedge clk);
    chk("R8 reset state", {dec_vld, accept, is_ucast, is_mcast, is_bcast}, 0);
    rst_n = 1'b1;

    // R6: group bins, individual table full to catch a wrong-table lookup
    ind_hash_hi = '1; ind_hash_lo = '1; promisc = 1'b1;
    for (int k = 0; k < 160; k++) begin
      a = {8'h01 | 8'(k << 2), 8'h5E, 16'h0, 16'(k * 37)};
      n = bin_of(a);
      {grp_hash_hi, grp_hash_lo} = 64'd1 << n;
      frame(a, k[0], "R5 R6 group bin set");
      {grp_hash_hi, grp_hash_lo} = ~(64'd1 << n);
      frame(a, 1'b0, "R6 group bin clear");
    end

    // R7: individual bins, group table full
    promisc = 1'b0; grp_hash_hi = '1; grp_hash_lo = '1;
    node_addr = 48'h0200_0000_0001;
    for (int s = 0; s < 4; s++) supp_addr[s] = 48'h0200_0000_0010 + 48'(s);
    for (int k = 0; k < 160; k++) begin
      a = {8'h02 | 8'(k << 2), 8'h11, 16'h1234, 16'(k * 53 + 7)};
      n = bin_of(a);
      {ind_hash_hi, ind_hash_lo} = 64'd1 << n;
      frame(a, k[0], "R5 R7 individual bin set");
      {ind_hash_hi, ind_hash_lo} = ~(64'd1 << n);
      frame(a, 1'b0, "R7 individual bin clear");
    end

    // R3: exact slots with hash tables empty
    ind_hash_hi = '0; ind_hash_lo = '0;
    frame(node_addr, 1'b0, "R3 node match");
    for (int s = 0; s < 4; s++) frame(supp_addr[s], s[0], "R3 supplemental match");
    frame(48'h0200_0000_0002, 1'b0, "R3 near miss");
    frame(48'h0200_0000_0014, 1'b1, "R3 near miss supplemental");

    // R4: promiscuous
    promisc = 1'b1;
    for (int k = 0; k < 8; k++) frame({8'h00, 8'(k), 32'hCAFE_0000 + 32'(k)}, k[0], "R4 promiscuous");
    frame(48'h0300_0000_0001, 1'b0, "R6 promisc ignored for group");
    promisc = 1'b0;

    // R2: broadcast
    grp_hash_hi = '0; grp_hash_lo = '0;
    frame('1, 1'b0, "R2 broadcast accepted");
    bcast_reject = 1'b1;
    frame('1, 1'b1, "R2 broadcast rejected");
    grp_hash_hi = '1; grp_hash_lo = '1;
    frame('1, 1'b0, "R2 broadcast rejected despite group table");
    bcast_reject = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule